// File: doc/BRIEF.md
# Audio Port FIFO and DMA Request Controller

This block sits between a bus-side register interface and the serializer of a stereo PCM audio port. It owns a transmit FIFO that software (or a DMA engine) fills through a data register and the serializer drains, and a receive FIFO that the serializer fills and software drains. A control/status register carries the per-direction run bits, the FIFO clear commands, the fill-threshold flags, the sticky error flags, a standby-release bit and a sync bit.

The PCM side is represented by a one-cycle enable, `pcm_tick_i`, that marks each PCM clock period. FIFO clears, the standby release and the sync echo all complete only after a fixed number of these ticks. Software can therefore toggle the sync bit and poll until the new value reads back, which tells it that the PCM side has seen its earlier writes. Each direction drives a normal DMA request and a higher-priority panic request. Both are formed by comparing the FIFO fill against levels that software programs. A level-sensitive interrupt is built from four maskable, write-one-to-clear status bits.

Top module: `audio_fifo_ctrl`

## Requirements
- R1: After reset the control register reads 0x002A_0000 (TX empty, TX can accept, TX needs writing), the level register reads 0x1030_3020, the interrupt enable reads 0, the DMA and interrupt outputs are low, and interrupt status bit 0 is set.
- R2: Register word addresses are control 0, data 1, levels 2, interrupt enable 3, interrupt status 4. Control bits read back as written: port enable 0, RX run 1, TX run 2, TX threshold 6:5, RX threshold 8:7, DMA enable 9, standby release 25. Status bits are TX clear busy 3, RX clear busy 4, TX error 15, RX error 16, TX needs writing 17, RX needs reading 18, TX can accept 19, RX has data 20, TX empty 21, RX full 22, sync echo 24.
- R3: Words written to the data register leave on `tx_data_o` in write order, one for each `tx_pop_i` while the port is active and TX runs.
- R4: Words pushed on `rx_data_i` read back from the data register in push order; each read pops one word.
- R5: The port is active only when the enable bit is set and 4 PCM ticks have passed since standby release was written from 0 to 1; serializer pushes and pops are ignored otherwise.
- R6: A write of 1 to TX clear or RX clear empties that FIFO on the 2nd PCM tick after the write; the clear bit reads 1 until then.
- R7: The sync bit reads back the value last written to bit 24 only after 2 PCM ticks.
- R8: A pop from an empty TX FIFO while TX runs sets the TX error bit. A push into a full 64-word RX FIFO while RX runs sets the RX error bit and drops the word. Writing 1 to an error bit clears it.
- R9: With TX run cleared, serializer pops are ignored while RX keeps accepting pushes.
- R10: With port enable and DMA enable set, the TX request is high while the TX fill is below levels bits 15:8, and the TX panic while it is below bits 31:24. The RX request is high while the RX fill is above bits 7:0, and the RX panic while it is above bits 23:16. All four are low without DMA enable.
- R11: TX needs writing is high when the TX fill is 0, below 16, below 32 or below 64 for threshold 0 to 3. RX needs reading is high when the RX fill is nonzero, at least 16, at least 32 or 64 for threshold 0 to 3.
- R12: Interrupt status bits are TX needs writing 0, RX needs reading 1, TX error 2, RX error 3. Each is set while its condition holds and cleared by writing 1 while it does not. `irq_o` is high when any status bit is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pcm_tick_i | input | 1 | One pulse per PCM clock period |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops RX on the data address) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| tx_pop_i | input | 1 | Serializer takes a TX word |
| tx_data_o | output | 32 | Head of the TX FIFO (0 when empty) |
| rx_push_i | input | 1 | Serializer delivers an RX word |
| rx_data_i | input | 32 | RX word from the serializer |
| tx_dreq_o | output | 1 | TX DMA request |
| rx_dreq_o | output | 1 | RX DMA request |
| tx_panic_o | output | 1 | TX panic request |
| rx_panic_o | output | 1 | RX panic request |
| irq_o | output | 1 | Interrupt |

## Verification
The hardest state to reach is a full RX FIFO with an extra push landing on it while the clear and standby timers are idle, since the port only becomes active after the tick-counted standby release. The bench first walks the port through standby with pushes that must be dropped, then pushes 65 words in a row and checks the error, full and request flags before using a tick-counted clear to empty the FIFO. Clears and the sync echo are probed one tick before and at their completion tick, so an off-by-one in the tick counters shows up.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;
  localparam int REG_W = 32;
  localparam int LVL_W = 8;

  localparam logic [2:0] A_CTRL     = 3'd0;
  localparam logic [2:0] A_DATA     = 3'd1;
  localparam logic [2:0] A_LEVEL    = 3'd2;
  localparam logic [2:0] A_IRQ_EN   = 3'd3;
  localparam logic [2:0] A_IRQ_STAT = 3'd4;

  localparam int B_EN    = 0;
  localparam int B_RXON  = 1;
  localparam int B_TXON  = 2;
  localparam int B_TXCLR = 3;
  localparam int B_RXCLR = 4;
  localparam int B_TXTHR = 5;
  localparam int B_RXTHR = 7;
  localparam int B_DMAEN = 9;
  localparam int B_TXERR = 15;
  localparam int B_RXERR = 16;
  localparam int B_TXW   = 17;
  localparam int B_RXR   = 18;
  localparam int B_TXD   = 19;
  localparam int B_RXD   = 20;
  localparam int B_TXE   = 21;
  localparam int B_RXF   = 22;
  localparam int B_SYNC  = 24;
  localparam int B_STBY  = 25;

  localparam logic [REG_W-1:0] LEVEL_RST = 32'h1030_3020;
endpackage

// File: rtl/audio_sfifo.sv
module audio_sfifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         push_i,
  input  logic [W-1:0]                 wdata_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 rdata_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full_o  = (count == CW'(DEPTH));
  assign empty_o = (count == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem[rd_ptr];
  assign count_o = count;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem[wr_ptr] <= wdata_i;
  end
endmodule

// File: rtl/pcm_tick_delay.sv
module pcm_tick_delay #(
  parameter int TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(TICKS+1);

  logic [CW-1:0] cnt;
  logic          busy;

  assign busy_o = busy;
  assign done_o = busy & tick_i & (cnt == CW'(TICKS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start_i) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy && tick_i) begin
      if (done_o) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/audio_fifo_ctrl.sv
module audio_fifo_ctrl
  import audio_fifo_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 64,
  parameter int CLR_TICKS  = 2,
  parameter int SYNC_TICKS = 2,
  parameter int STBY_TICKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pcm_tick_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              tx_dreq_o,
  output logic              rx_dreq_o,
  output logic              tx_panic_o,
  output logic              rx_panic_o,
  output logic              irq_o
);
  localparam int CW   = $clog2(DEPTH+1);
  localparam int QTR  = DEPTH / 4;
  localparam int HALF = DEPTH / 2;

  logic             en_q, rx_on_q, tx_on_q, dma_en_q;
  logic [1:0]       tx_thr_q, rx_thr_q;
  logic             tx_err_q, rx_err_q;
  logic             sync_wr_q, sync_rd_q;
  logic             stby_req_q, stby_ok_q;
  logic [REG_W-1:0] level_q;
  logic [3:0]       irq_en_q, irq_stat_q;

  logic ctrl_wr, data_wr, data_rd, level_wr, irq_en_wr, irq_stat_wr;
  logic port_ready, tx_active, rx_active;
  logic tx_underflow, rx_overflow;
  logic tx_clr_busy, tx_clr_done, rx_clr_busy, rx_clr_done;
  logic sync_done, stby_done, stby_start;
  logic unused_sync_busy, unused_stby_busy;

  logic [DATA_W-1:0] tx_head, rx_head;
  logic [CW-1:0]     tx_count, rx_count;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              txw, rxr, dma_on;
  logic [3:0]        irq_cond;
  logic [REG_W-1:0]  csr;

  assign ctrl_wr     = reg_we_i & (reg_addr_i == A_CTRL);
  assign data_wr     = reg_we_i & (reg_addr_i == A_DATA);
  assign data_rd     = reg_re_i & (reg_addr_i == A_DATA);
  assign level_wr    = reg_we_i & (reg_addr_i == A_LEVEL);
  assign irq_en_wr   = reg_we_i & (reg_addr_i == A_IRQ_EN);
  assign irq_stat_wr = reg_we_i & (reg_addr_i == A_IRQ_STAT);

  assign port_ready   = en_q & stby_ok_q;
  assign tx_active    = port_ready & tx_on_q;
  assign rx_active    = port_ready & rx_on_q;
  assign tx_underflow = tx_active & tx_pop_i & tx_empty;
  assign rx_overflow  = rx_active & rx_push_i & rx_full;
  assign stby_start   = ctrl_wr & reg_wdata_i[B_STBY] & ~stby_req_q;

  audio_sfifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .clr_i   (tx_clr_done),
    .push_i  (data_wr),
    .wdata_i (reg_wdata_i[DATA_W-1:0]),
    .pop_i   (tx_active & tx_pop_i),
    .rdata_o (tx_head),
    .count_o (tx_count),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  audio_sfifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .clr_i   (rx_clr_done),
    .push_i  (rx_active & rx_push_i),
    .wdata_i (rx_data_i),
    .pop_i   (data_rd),
    .rdata_o (rx_head),
    .count_o (rx_count),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  pcm_tick_delay #(.TICKS(CLR_TICKS)) u_tx_clr (
    .clk_i, .rst_ni, .start_i(ctrl_wr & reg_wdata_i[B_TXCLR]), .tick_i(pcm_tick_i),
    .busy_o(tx_clr_busy), .done_o(tx_clr_done));

  pcm_tick_delay #(.TICKS(CLR_TICKS)) u_rx_clr (
    .clk_i, .rst_ni, .start_i(ctrl_wr & reg_wdata_i[B_RXCLR]), .tick_i(pcm_tick_i),
    .busy_o(rx_clr_busy), .done_o(rx_clr_done));

  pcm_tick_delay #(.TICKS(SYNC_TICKS)) u_sync (
    .clk_i, .rst_ni, .start_i(ctrl_wr), .tick_i(pcm_tick_i),
    .busy_o(unused_sync_busy), .done_o(sync_done));

  pcm_tick_delay #(.TICKS(STBY_TICKS)) u_stby (
    .clk_i, .rst_ni, .start_i(stby_start), .tick_i(pcm_tick_i),
    .busy_o(unused_stby_busy), .done_o(stby_done));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      rx_on_q    <= 1'b0;
      tx_on_q    <= 1'b0;
      tx_thr_q   <= '0;
      rx_thr_q   <= '0;
      dma_en_q   <= 1'b0;
      sync_wr_q  <= 1'b0;
      sync_rd_q  <= 1'b0;
      stby_req_q <= 1'b0;
      stby_ok_q  <= 1'b0;
      tx_err_q   <= 1'b0;
      rx_err_q   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q       <= reg_wdata_i[B_EN];
        rx_on_q    <= reg_wdata_i[B_RXON];
        tx_on_q    <= reg_wdata_i[B_TXON];
        tx_thr_q   <= reg_wdata_i[B_TXTHR +: 2];
        rx_thr_q   <= reg_wdata_i[B_RXTHR +: 2];
        dma_en_q   <= reg_wdata_i[B_DMAEN];
        sync_wr_q  <= reg_wdata_i[B_SYNC];
        stby_req_q <= reg_wdata_i[B_STBY];
      end
      if (sync_done) sync_rd_q <= sync_wr_q;
      if (ctrl_wr && !reg_wdata_i[B_STBY]) stby_ok_q <= 1'b0;
      else if (stby_done && stby_req_q)    stby_ok_q <= 1'b1;
      // set wins over a same-cycle write-one-to-clear
      tx_err_q <= tx_underflow | (tx_err_q & ~(ctrl_wr & reg_wdata_i[B_TXERR]));
      rx_err_q <= rx_overflow  | (rx_err_q & ~(ctrl_wr & reg_wdata_i[B_RXERR]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q    <= LEVEL_RST;
      irq_en_q   <= '0;
      irq_stat_q <= '0;
    end else begin
      if (level_wr)  level_q  <= reg_wdata_i;
      if (irq_en_wr) irq_en_q <= reg_wdata_i[3:0];
      irq_stat_q <= (irq_stat_q & ~(irq_stat_wr ? reg_wdata_i[3:0] : 4'b0)) | irq_cond;
    end
  end

  always_comb begin
    unique case (tx_thr_q)
      2'd0:    txw = (tx_count == '0);
      2'd1:    txw = (tx_count < CW'(QTR));
      2'd2:    txw = (tx_count < CW'(HALF));
      default: txw = ~tx_full;
    endcase
    unique case (rx_thr_q)
      2'd0:    rxr = ~rx_empty;
      2'd1:    rxr = (rx_count >= CW'(QTR));
      2'd2:    rxr = (rx_count >= CW'(HALF));
      default: rxr = rx_full;
    endcase
  end

  assign irq_cond = {rx_err_q, tx_err_q, rxr, txw};
  assign irq_o    = |(irq_stat_q & irq_en_q);

  assign dma_on     = en_q & dma_en_q;
  assign tx_dreq_o  = dma_on & (32'(tx_count) < 32'(level_q[15:8]));
  assign tx_panic_o = dma_on & (32'(tx_count) < 32'(level_q[31:24]));
  assign rx_dreq_o  = dma_on & (32'(rx_count) > 32'(level_q[7:0]));
  assign rx_panic_o = dma_on & (32'(rx_count) > 32'(level_q[23:16]));

  assign tx_data_o = tx_empty ? '0 : tx_head;

  always_comb begin
    csr                  = '0;
    csr[B_EN]            = en_q;
    csr[B_RXON]          = rx_on_q;
    csr[B_TXON]          = tx_on_q;
    csr[B_TXCLR]         = tx_clr_busy;
    csr[B_RXCLR]         = rx_clr_busy;
    csr[B_TXTHR +: 2]    = tx_thr_q;
    csr[B_RXTHR +: 2]    = rx_thr_q;
    csr[B_DMAEN]         = dma_en_q;
    csr[B_TXERR]         = tx_err_q;
    csr[B_RXERR]         = rx_err_q;
    csr[B_TXW]           = txw;
    csr[B_RXR]           = rxr;
    csr[B_TXD]           = ~tx_full;
    csr[B_RXD]           = ~rx_empty;
    csr[B_TXE]           = tx_empty;
    csr[B_RXF]           = rx_full;
    csr[B_SYNC]          = sync_rd_q;
    csr[B_STBY]          = stby_req_q;
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:     reg_rdata_o = csr;
      A_DATA:     reg_rdata_o = rx_empty ? '0 : REG_W'(rx_head);
      A_LEVEL:    reg_rdata_o = level_q;
      A_IRQ_EN:   reg_rdata_o = {28'b0, irq_en_q};
      A_IRQ_STAT: reg_rdata_o = {28'b0, irq_stat_q};
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/audio_fifo_ctrl_chk.sv
module audio_fifo_ctrl_chk #(
  parameter int DEPTH = 64
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       port_ready,
  input logic                       rx_active,
  input logic                       rx_push_i,
  input logic                       rx_full,
  input logic                       rx_err_q,
  input logic [$clog2(DEPTH+1)-1:0] rx_count,
  input logic [$clog2(DEPTH+1)-1:0] tx_count,
  input logic                       tx_clr_done,
  input logic                       sync_done,
  input logic                       sync_rd_q,
  input logic                       stby_ok_q,
  input logic                       stby_done,
  input logic                       tx_panic_o,
  input logic                       tx_dreq_o,
  input logic [31:0]                level_q
);
  a_r8_rx_overflow_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_active && rx_push_i && rx_full) |=> rx_err_q);

  a_r5_idle_no_rx_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_ready |=> (rx_count <= $past(rx_count)));

  a_r5_ready_after_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stby_ok_q) |-> $past(stby_done));

  a_r6_clear_empties_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_clr_done |=> (tx_count == '0));

  a_r7_sync_moves_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_done |=> $stable(sync_rd_q));

  a_r10_panic_implies_dreq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_panic_o && (level_q[31:24] <= level_q[15:8])) |-> tx_dreq_o);

  a_r3_tx_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tx_count) <= DEPTH);
endmodule

bind audio_fifo_ctrl audio_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .port_ready  (port_ready),
  .rx_active   (rx_active),
  .rx_push_i   (rx_push_i),
  .rx_full     (rx_full),
  .rx_err_q    (rx_err_q),
  .rx_count    (rx_count),
  .tx_count    (tx_count),
  .tx_clr_done (tx_clr_done),
  .sync_done   (sync_done),
  .sync_rd_q   (sync_rd_q),
  .stby_ok_q   (stby_ok_q),
  .stby_done   (stby_done),
  .tx_panic_o  (tx_panic_o),
  .tx_dreq_o   (tx_dreq_o),
  .level_q     (level_q)
);

// File: tb/sim_audio_fifo_ctrl.sv
`timescale 1ns/1ps
module sim_audio_fifo_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx_pop = 1'b0;
  logic [31:0] tx_data;
  logic        rx_push = 1'b0;
  logic [31:0] rx_data = '0;
  logic        tx_dreq, rx_dreq, tx_panic, rx_panic, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit mon_tx   = 1'b0;
  bit finished = 1'b0;
  logic [31:0] tx_q[$];
  logic [31:0] rx_q[$];

  always #10 clk = ~clk;

  audio_fifo_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .pcm_tick_i(tick),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tx_pop_i(tx_pop), .tx_data_o(tx_data), .rx_push_i(rx_push), .rx_data_i(rx_data),
    .tx_dreq_o(tx_dreq), .rx_dreq_o(rx_dreq), .tx_panic_o(tx_panic), .rx_panic_o(rx_panic),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic push(input logic [31:0] d, input bit expect_kept);
    @(negedge clk); rx_push = 1'b1; rx_data = d;
    if (expect_kept) rx_q.push_back(d);
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic rx_read_check(input string tag);
    logic [31:0] d;
    rd(3'd1, d);
    chk(tag, d, rx_q.pop_front());
  endtask

  function automatic logic [31:0] bitv(input logic [31:0] v, input int b);
    return {31'b0, v[b]};
  endfunction

  // scoreboard monitor for the TX stream
  always @(negedge clk) begin
    #2;
    if (mon_tx && tx_pop) begin
      if (tx_q.size() == 0) chk("R3 tx extra pop", tx_data, 32'hx);
      else chk("R3 tx order", tx_data, tx_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog (all requirements) got=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] cur;
    localparam logic [31:0] CFG = 32'h0200_0247;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(3'd0, d); chk("R1 ctrl reset", d, 32'h002A_0000);
    rd(3'd2, d); chk("R1 level reset", d, 32'h1030_3020);
    rd(3'd3, d); chk("R1 irq enable reset", d, 32'h0);
    rd(3'd4, d); chk("R1 irq status reset", d, 32'h1);
    chk("R1 outputs low", {27'b0, tx_dreq, rx_dreq, tx_panic, rx_panic, irq}, 32'h0);

    // R2 configuration readback
    cur = CFG;
    wr(3'd0, cur);
    rd(3'd0, d); chk("R2 config bits", d & 32'h0200_03E7, CFG);

    // R5 standby release needs 4 ticks
    push(32'h11, 1'b0);
    rd(3'd0, d); chk("R5 push ignored in standby", bitv(d, 20), 32'h0);
    ticks(3);
    push(32'h22, 1'b0);
    rd(3'd0, d); chk("R5 push ignored after 3 ticks", bitv(d, 20), 32'h0);
    ticks(1);
    for (int i = 0; i < 3; i++) push(32'hA1 + i, 1'b1);
    rd(3'd0, d); chk("R5 port active after 4 ticks", bitv(d, 20), 32'h1);

    // R4 RX order
    for (int i = 0; i < 3; i++) rx_read_check("R4 rx order");
    rd(3'd0, d); chk("R4 rx drained", bitv(d, 20), 32'h0);

    // R3 TX order through scoreboard
    for (int i = 0; i < 5; i++) begin
      tx_q.push_back(32'hB0 + i);
      wr(3'd1, 32'hB0 + i);
    end
    mon_tx = 1'b1;
    for (int i = 0; i < 5; i++) pop();
    mon_tx = 1'b0;
    chk("R3 all words delivered", tx_q.size(), 32'h0);
    rd(3'd0, d); chk("R3 tx empty", bitv(d, 21), 32'h1);

    // R8 TX underflow and R12 interrupt path
    pop();
    rd(3'd0, d); chk("R8 tx underflow error", bitv(d, 15), 32'h1);
    rd(3'd4, d); chk("R12 status tx error", bitv(d, 2), 32'h1);
    wr(3'd3, 32'h4);
    #1 chk("R12 irq asserted", {31'b0, irq}, 32'h1);
    wr(3'd0, cur | (32'h1 << 15));
    rd(3'd0, d); chk("R8 tx error cleared", bitv(d, 15), 32'h0);
    wr(3'd4, 32'h4);
    #1 chk("R12 irq cleared", {31'b0, irq}, 32'h0);

    // R8 RX overflow, R10 and R11 at full
    for (int i = 0; i < 64; i++) push(32'hC00 + i, 1'b1);
    push(32'hDEAD, 1'b0);
    rd(3'd0, d);
    chk("R8 rx overflow error", bitv(d, 16), 32'h1);
    chk("R8 rx full", bitv(d, 22), 32'h1);
    chk("R11 rx needs reading thr0", bitv(d, 18), 32'h1);
    #1 chk("R10 requests at rx full tx empty", {28'b0, tx_dreq, tx_panic, rx_dreq, rx_panic}, 32'hF);
    rx_read_check("R8 first word kept");
    rx_q.delete();

    // R6 RX clear after 2 ticks
    wr(3'd0, cur | (32'h1 << 4) | (32'h1 << 16));
    rd(3'd0, d);
    chk("R6 clear busy", bitv(d, 4), 32'h1);
    chk("R6 data before ticks", bitv(d, 20), 32'h1);
    ticks(1);
    rd(3'd0, d);
    chk("R6 clear busy after 1 tick", bitv(d, 4), 32'h1);
    chk("R6 data after 1 tick", bitv(d, 20), 32'h1);
    ticks(1);
    rd(3'd0, d);
    chk("R6 clear done", bitv(d, 4), 32'h0);
    chk("R6 rx emptied", bitv(d, 20), 32'h0);
    chk("R8 rx error cleared", bitv(d, 16), 32'h0);

    // R9 TX stopped, RX continues
    cur = CFG & ~32'h4;
    wr(3'd0, cur);
    wr(3'd1, 32'hE1);
    pop();
    rd(3'd0, d);
    chk("R9 tx pop ignored", bitv(d, 21), 32'h0);
    chk("R9 no tx error", bitv(d, 15), 32'h0);
    push(32'hF1, 1'b1);
    rx_read_check("R9 rx keeps running");

    // R10 programmed levels
    wr(3'd2, 32'h0105_0200);
    #1 chk("R10 tx fill 1 rx empty", {28'b0, tx_dreq, tx_panic, rx_dreq, rx_panic}, 32'h8);
    push(32'hF2, 1'b1);
    #1 chk("R10 rx fill 1", {28'b0, tx_dreq, tx_panic, rx_dreq, rx_panic}, 32'hA);
    cur = cur & ~(32'h1 << 9);
    wr(3'd0, cur);
    #1 chk("R10 dma disabled", {28'b0, tx_dreq, tx_panic, rx_dreq, rx_panic}, 32'h0);

    // R11 threshold flags
    rd(3'd0, d); chk("R11 tx thr2 fill1", bitv(d, 17), 32'h1);
    cur = cur & ~(32'h3 << 5);
    wr(3'd0, cur);
    rd(3'd0, d);
    chk("R11 tx thr0 fill1", bitv(d, 17), 32'h0);
    chk("R11 rx thr0 fill1", bitv(d, 18), 32'h1);
    cur = cur | (32'h1 << 7);
    wr(3'd0, cur);
    rd(3'd0, d); chk("R11 rx thr1 fill1", bitv(d, 18), 32'h0);

    // R7 sync echo after 2 ticks
    cur = cur | (32'h1 << 24);
    wr(3'd0, cur);
    rd(3'd0, d); chk("R7 sync before ticks", bitv(d, 24), 32'h0);
    ticks(1);
    rd(3'd0, d); chk("R7 sync after 1 tick", bitv(d, 24), 32'h0);
    ticks(1);
    rd(3'd0, d); chk("R7 sync after 2 ticks", bitv(d, 24), 32'h1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule